// File: doc/BRIEF.md
# Three-State Snooping Invalidate Coherence Controller

This block tracks coherence state for the lines of one processor's cache that sits on a shared snooping bus. Every tracked entry holds a tag and one of three states: invalid, shared or dirty. The processor side presents read and write requests for a line index and tag. The controller either completes them locally in the same cycle or raises a bus request and stalls the processor until the bus grants that transaction. Writes to a shared copy first broadcast an invalidate. Once a line is dirty it is accessed with no bus traffic.

The snoop side watches transactions from other caches. A snooped invalidate or read-exclusive removes the local copy. A snooped read of a dirty line makes this cache supply the data through a one-cycle pulse, and the line drops to shared. A snoop to the same index as a pending processor request takes that cycle, and the processor request waits. Data arrays, victim handling and arbitration between caches are handled elsewhere.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: After reset every entry is invalid. The first processor access to any index therefore needs a bus transaction. No entry ever holds the unused state code 3.
- R2: A processor read to an invalid entry, or to an entry whose tag differs, requests bus op 1 (read). After the grant the entry is shared with the new tag.
- R3: A processor read that hits a shared entry completes in the cycle it is presented, with no bus request.
- R4: A processor write that hits a shared entry requests bus op 3 (invalidate). After the grant the entry is dirty.
- R5: A processor write to an invalid or tag-mismatched entry requests bus op 2 (read-exclusive). After the grant the entry is dirty.
- R6: Processor reads and writes that hit a dirty entry complete in the cycle they are presented, with no bus request.
- R7: While a bus transaction is needed, `cpu_rdy` stays low and `bus_req` stays high with the op held. `cpu_rdy` rises in the cycle `bus_gnt` is high. With no processor request, `bus_req` is low.
- R8: A snooped read (snoop op 1) that hits a dirty entry drives `snp_supply` high for exactly the cycle after the snoop. The entry becomes shared.
- R9: A snooped read that hits a shared entry, or that finds the entry invalid, changes nothing and gives no supply pulse.
- R10: A snooped invalidate (op 3) or read-exclusive (op 2) that hits the entry makes it invalid. A read-exclusive that hits a dirty entry also pulses `snp_supply`.
- R11: When a valid snoop names the same index as a processor request in the same cycle, the snoop is applied. In that cycle `cpu_rdy` and `bus_req` stay low.
- R12: A snoop whose tag differs from the stored tag has no effect on the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Processor request valid |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_idx | input | IDX_W | Line index of request |
| cpu_tag | input | TAG_W | Tag of request |
| cpu_rdy | output | 1 | Request completes this cycle |
| bus_req | output | 1 | Bus transaction wanted |
| bus_op | output | 2 | 1 read, 2 read-exclusive, 3 invalidate |
| bus_idx | output | IDX_W | Index of bus transaction |
| bus_tag | output | TAG_W | Tag of bus transaction |
| bus_gnt | input | 1 | Bus grants the pending transaction |
| snp_vld | input | 1 | Snooped transaction valid |
| snp_op | input | 2 | Snooped op, same coding as bus_op |
| snp_idx | input | IDX_W | Snooped line index |
| snp_tag | input | TAG_W | Snooped tag |
| snp_supply | output | 1 | One-cycle write-back / supply pulse |

## Verification
The bench builds the block with its defaults of eight entries and 8-bit tags. Eight entries are enough to keep several lines in different states at once, so transitions on one index can be seen to leave the others untouched. With 8-bit tags the bench can present a second tag on an occupied index, which reaches the mismatch cases of R2 and R12. A granted bus stall of several cycles and a snoop that collides with a processor request on one index are both driven directly.

// File: rtl/coh_pkg.sv
package coh_pkg;
    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_DRT = 2'd2
    } line_state_e;

    typedef enum logic [1:0] {
        BOP_NONE  = 2'd0,
        BOP_READ  = 2'd1,
        BOP_READX = 2'd2,
        BOP_INVAL = 2'd3
    } bus_op_e;
endpackage

// File: rtl/coh_line_table.sv
module coh_line_table
    import coh_pkg::*;
#(
    parameter int LINES = 8,
    parameter int TAG_W = 8,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] cpu_rd_idx,
    output line_state_e      cpu_rd_st,
    output logic [TAG_W-1:0] cpu_rd_tag,
    input  logic [IDX_W-1:0] snp_rd_idx,
    output line_state_e      snp_rd_st,
    output logic [TAG_W-1:0] snp_rd_tag,
    input  logic             cpu_we,
    input  logic [IDX_W-1:0] cpu_wr_idx,
    input  line_state_e      cpu_wr_st,
    input  logic [TAG_W-1:0] cpu_wr_tag,
    input  logic             snp_we,
    input  logic [IDX_W-1:0] snp_wr_idx,
    input  line_state_e      snp_wr_st
);
    typedef struct packed {
        logic [LINES-1:0][1:0]       st;
        logic [LINES-1:0][TAG_W-1:0] tag;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (cpu_we) begin
            tbl_d.st[cpu_wr_idx]  = cpu_wr_st;
            tbl_d.tag[cpu_wr_idx] = cpu_wr_tag;
        end
        if (snp_we) begin
            tbl_d.st[snp_wr_idx] = snp_wr_st;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign cpu_rd_st  = line_state_e'(tbl_q.st[cpu_rd_idx]);
    assign cpu_rd_tag = tbl_q.tag[cpu_rd_idx];
    assign snp_rd_st  = line_state_e'(tbl_q.st[snp_rd_idx]);
    assign snp_rd_tag = tbl_q.tag[snp_rd_idx];

    AST_PORT_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && snp_we) |-> (cpu_wr_idx != snp_wr_idx)); // R11

    for (genvar g = 0; g < LINES; g++) begin : g_legal
        AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
            tbl_q.st[g] != 2'd3); // R1
    end
endmodule

// File: rtl/coh_cpu_ctrl.sv
module coh_cpu_ctrl
    import coh_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_req,
    input  logic             cpu_wr,
    input  logic [TAG_W-1:0] cpu_tag,
    input  line_state_e      cur_st,
    input  logic [TAG_W-1:0] cur_tag,
    input  logic             snoop_block,
    input  logic             bus_gnt,
    output logic             cpu_rdy,
    output logic             bus_req,
    output bus_op_e          bus_op,
    output logic             upd_we,
    output line_state_e      upd_st
);
    line_state_e eff_st;
    line_state_e nxt_st;
    bus_op_e     need_op;

    always_comb begin
        eff_st = (cur_st != LS_INV && cur_tag == cpu_tag) ? cur_st : LS_INV;
        need_op = BOP_NONE;
        nxt_st  = eff_st;
        if (!cpu_wr) begin
            if (eff_st == LS_INV) begin
                need_op = BOP_READ;
                nxt_st  = LS_SHR;
            end
        end else begin
            unique case (eff_st)
                LS_INV:  begin need_op = BOP_READX; nxt_st = LS_DRT; end
                LS_SHR:  begin need_op = BOP_INVAL; nxt_st = LS_DRT; end
                default: begin need_op = BOP_NONE;  nxt_st = LS_DRT; end
            endcase
        end

        cpu_rdy = 1'b0;
        bus_req = 1'b0;
        bus_op  = BOP_NONE;
        upd_we  = 1'b0;
        upd_st  = nxt_st;
        if (cpu_req && !snoop_block) begin
            if (need_op == BOP_NONE) begin
                cpu_rdy = 1'b1;
                upd_we  = 1'b1;
            end else begin
                bus_req = 1'b1;
                bus_op  = need_op;
                if (bus_gnt) begin
                    cpu_rdy = 1'b1;
                    upd_we  = 1'b1;
                end
            end
        end
    end

    AST_GRANT_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rdy && bus_req) |-> bus_gnt); // R7
    AST_RDY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdy |-> cpu_req); // R7
endmodule

// File: rtl/coh_snoop_ctrl.sv
module coh_snoop_ctrl
    import coh_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snp_vld,
    input  bus_op_e          snp_op,
    input  logic [TAG_W-1:0] snp_tag,
    input  line_state_e      cur_st,
    input  logic [TAG_W-1:0] cur_tag,
    output logic             upd_we,
    output line_state_e      upd_st,
    output logic             supply
);
    logic hit;
    logic supply_d, supply_q;

    always_comb begin
        hit      = snp_vld && (cur_st != LS_INV) && (cur_tag == snp_tag);
        upd_we   = 1'b0;
        upd_st   = cur_st;
        supply_d = 1'b0;
        if (hit) begin
            unique case (snp_op)
                BOP_READ: begin
                    if (cur_st == LS_DRT) begin
                        upd_we   = 1'b1;
                        upd_st   = LS_SHR;
                        supply_d = 1'b1;
                    end
                end
                BOP_READX: begin
                    upd_we   = 1'b1;
                    upd_st   = LS_INV;
                    supply_d = (cur_st == LS_DRT);
                end
                BOP_INVAL: begin
                    upd_we = 1'b1;
                    upd_st = LS_INV;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) supply_q <= 1'b0;
        else        supply_q <= supply_d;
    end

    assign supply = supply_q;

    AST_SUPPLY_FROM_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        supply_d |=> supply); // R8
endmodule

// File: rtl/snoop_coh_ctrl.sv
module snoop_coh_ctrl
    import coh_pkg::*;
#(
    parameter int LINES = 8,
    parameter int TAG_W = 8,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_req,
    input  logic             cpu_wr,
    input  logic [IDX_W-1:0] cpu_idx,
    input  logic [TAG_W-1:0] cpu_tag,
    output logic             cpu_rdy,
    output logic             bus_req,
    output logic [1:0]       bus_op,
    output logic [IDX_W-1:0] bus_idx,
    output logic [TAG_W-1:0] bus_tag,
    input  logic             bus_gnt,
    input  logic             snp_vld,
    input  logic [1:0]       snp_op,
    input  logic [IDX_W-1:0] snp_idx,
    input  logic [TAG_W-1:0] snp_tag,
    output logic             snp_supply
);
    line_state_e      c_st, s_st, c_upd_st, s_upd_st;
    logic [TAG_W-1:0] c_tag, s_tag;
    logic             c_we, s_we, block;
    bus_op_e          op_e;

    assign block = snp_vld && cpu_req && (snp_idx == cpu_idx);

    coh_line_table #(.LINES(LINES), .TAG_W(TAG_W)) u_tbl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_rd_idx (cpu_idx),
        .cpu_rd_st  (c_st),
        .cpu_rd_tag (c_tag),
        .snp_rd_idx (snp_idx),
        .snp_rd_st  (s_st),
        .snp_rd_tag (s_tag),
        .cpu_we     (c_we),
        .cpu_wr_idx (cpu_idx),
        .cpu_wr_st  (c_upd_st),
        .cpu_wr_tag (cpu_tag),
        .snp_we     (s_we),
        .snp_wr_idx (snp_idx),
        .snp_wr_st  (s_upd_st)
    );

    coh_cpu_ctrl #(.TAG_W(TAG_W)) u_cpu (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_req     (cpu_req),
        .cpu_wr      (cpu_wr),
        .cpu_tag     (cpu_tag),
        .cur_st      (c_st),
        .cur_tag     (c_tag),
        .snoop_block (block),
        .bus_gnt     (bus_gnt),
        .cpu_rdy     (cpu_rdy),
        .bus_req     (bus_req),
        .bus_op      (op_e),
        .upd_we      (c_we),
        .upd_st      (c_upd_st)
    );

    coh_snoop_ctrl #(.TAG_W(TAG_W)) u_snp (
        .clk     (clk),
        .rst_n   (rst_n),
        .snp_vld (snp_vld),
        .snp_op  (bus_op_e'(snp_op)),
        .snp_tag (snp_tag),
        .cur_st  (s_st),
        .cur_tag (s_tag),
        .upd_we  (s_we),
        .upd_st  (s_upd_st),
        .supply  (snp_supply)
    );

    assign bus_op  = op_e;
    assign bus_idx = cpu_idx;
    assign bus_tag = cpu_tag;

    AST_SNOOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_vld && cpu_req && snp_idx == cpu_idx) |-> (!cpu_rdy && !bus_req)); // R11
    AST_SUPPLY_AFTER_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |-> $past(snp_vld && snp_op != 2'd0 && snp_op != 2'd3)); // R8
    AST_IDLE_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_req |-> !bus_req); // R7
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && !snp_vld) |=> (!cpu_req || bus_req || snp_vld)); // R7
endmodule

// File: tb/snoop_coh_ctrl_bench.sv
module snoop_coh_ctrl_bench;
    import coh_pkg::*;
    localparam int CLK_PER = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_req = 1'b0, cpu_wr = 1'b0;
    logic [2:0] cpu_idx = '0;
    logic [7:0] cpu_tag = '0;
    logic       cpu_rdy, bus_req, bus_gnt = 1'b0;
    logic [1:0] bus_op;
    logic [2:0] bus_idx;
    logic [7:0] bus_tag;
    logic       snp_vld = 1'b0;
    logic [1:0] snp_op = '0;
    logic [2:0] snp_idx = '0;
    logic [7:0] snp_tag = '0;
    logic       snp_supply;

    int checks = 0;
    int fails = 0;
    logic [4:0] exp_q[$];

    always #(CLK_PER/2) clk = ~clk;

    snoop_coh_ctrl u_snoop_coh_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_wr(cpu_wr),
        .cpu_idx(cpu_idx), .cpu_tag(cpu_tag), .cpu_rdy(cpu_rdy),
        .bus_req(bus_req), .bus_op(bus_op), .bus_idx(bus_idx), .bus_tag(bus_tag),
        .bus_gnt(bus_gnt), .snp_vld(snp_vld), .snp_op(snp_op),
        .snp_idx(snp_idx), .snp_tag(snp_tag), .snp_supply(snp_supply)
    );

    task automatic check(input string rq, input logic ok,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // monitor: pops the scoreboard whenever a granted transaction is seen
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PER/2 - 1);
            if (bus_req && bus_gnt) begin
                if (exp_q.size() == 0) begin
                    check("R7 unexpected grant", 1'b0, {27'd0, bus_op, bus_idx}, 32'd0);
                end else begin
                    logic [4:0] e;
                    e = exp_q.pop_front();
                    check("R2/R4/R5 scoreboard op", {bus_op, bus_idx} == e,
                          {27'd0, bus_op, bus_idx}, {27'd0, e});
                end
            end
        end
    end

    // stall: extra cycles held before the grant
    task automatic cpu_access(input logic wr, input logic [2:0] idx, input logic [7:0] tag,
                              input logic [1:0] exp_op, input int stall, input string rq);
        @(negedge clk);
        cpu_req = 1'b1; cpu_wr = wr; cpu_idx = idx; cpu_tag = tag; bus_gnt = 1'b0;
        #1;
        if (exp_op == 2'd0) begin
            check(rq, cpu_rdy && !bus_req, {30'd0, cpu_rdy, bus_req}, 32'h2);
        end else begin
            exp_q.push_back({exp_op, idx});
            check(rq, !cpu_rdy && bus_req && bus_op == exp_op,
                  {28'd0, cpu_rdy, bus_req, bus_op}, {28'd0, 2'b01, exp_op});
            for (int k = 0; k < stall; k++) begin
                @(negedge clk); #1;
                check("R7 stall holds", !cpu_rdy && bus_req && bus_op == exp_op,
                      {28'd0, cpu_rdy, bus_req, bus_op}, {28'd0, 2'b01, exp_op});
            end
            @(negedge clk);
            bus_gnt = 1'b1;
            #1;
            check("R7 ready with grant", cpu_rdy, {31'd0, cpu_rdy}, 32'd1);
        end
        @(negedge clk);
        cpu_req = 1'b0; bus_gnt = 1'b0;
    endtask

    task automatic snoop(input logic [1:0] op, input logic [2:0] idx, input logic [7:0] tag,
                         input logic exp_sup, input string rq);
        @(negedge clk);
        snp_vld = 1'b1; snp_op = op; snp_idx = idx; snp_tag = tag;
        @(negedge clk);
        snp_vld = 1'b0;
        #1;
        check(rq, snp_supply == exp_sup, {31'd0, snp_supply}, {31'd0, exp_sup});
        @(negedge clk); #1;
        check("R8 supply lasts one cycle", !snp_supply, {31'd0, snp_supply}, 32'd0);
    endtask

    initial begin
        #(CLK_PER * 20000);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset idle outputs", !cpu_rdy && !bus_req && !snp_supply,
              {29'd0, cpu_rdy, bus_req, snp_supply}, 32'd0);
        rst_n = 1'b1;

        // R1 / R2: fresh entry needs a bus read, stall of 2 cycles (R7)
        cpu_access(1'b0, 3'd0, 8'h10, 2'd1, 2, "R1 first read goes to bus");
        cpu_access(1'b0, 3'd1, 8'h11, 2'd1, 0, "R2 read miss requests read");
        cpu_access(1'b0, 3'd1, 8'h11, 2'd0, 0, "R3 shared read local");
        cpu_access(1'b1, 3'd1, 8'h11, 2'd3, 1, "R4 write shared invalidates");
        cpu_access(1'b1, 3'd1, 8'h11, 2'd0, 0, "R6 dirty write local");
        cpu_access(1'b0, 3'd1, 8'h11, 2'd0, 0, "R6 dirty read local");
        snoop(2'd1, 3'd1, 8'h11, 1'b1, "R8 snooped read of dirty supplies");
        cpu_access(1'b0, 3'd1, 8'h11, 2'd0, 0, "R8 line now shared, read local");
        cpu_access(1'b1, 3'd1, 8'h11, 2'd3, 0, "R8 line was shared, write invalidates");
        snoop(2'd1, 3'd1, 8'h11, 1'b1, "R8 second supply");
        snoop(2'd1, 3'd1, 8'h11, 1'b0, "R9 snooped read of shared no supply");
        cpu_access(1'b0, 3'd1, 8'h11, 2'd0, 0, "R9 shared unchanged");
        snoop(2'd3, 3'd1, 8'h11, 1'b0, "R10 snooped invalidate");
        cpu_access(1'b0, 3'd1, 8'h11, 2'd1, 0, "R10 line invalid after invalidate");
        cpu_access(1'b1, 3'd2, 8'h22, 2'd2, 1, "R5 write miss read-exclusive");
        cpu_access(1'b0, 3'd2, 8'h22, 2'd0, 0, "R5 line dirty after write miss");
        snoop(2'd2, 3'd2, 8'h22, 1'b1, "R10 read-exclusive on dirty supplies");
        cpu_access(1'b0, 3'd2, 8'h22, 2'd1, 0, "R10 line invalid after read-exclusive");
        cpu_access(1'b0, 3'd2, 8'h33, 2'd1, 0, "R2 tag mismatch treated as miss");
        cpu_access(1'b1, 3'd2, 8'h22, 2'd2, 0, "R5 old tag replaced, write is miss");
        cpu_access(1'b1, 3'd4, 8'h44, 2'd2, 0, "R5 write miss index 4");
        snoop(2'd1, 3'd4, 8'h55, 1'b0, "R12 snoop other tag no supply");
        snoop(2'd3, 3'd4, 8'h55, 1'b0, "R12 invalidate other tag ignored");
        cpu_access(1'b1, 3'd4, 8'h44, 2'd0, 0, "R12 entry still dirty");
        snoop(2'd1, 3'd6, 8'h66, 1'b0, "R9 snoop read on invalid no supply");
        cpu_access(1'b0, 3'd6, 8'h66, 2'd1, 0, "R9 invalid entry stays invalid");
        cpu_access(1'b0, 3'd0, 8'h10, 2'd0, 0, "R3 other entry kept shared");

        // R11: collision of snoop and processor on index 5
        cpu_access(1'b0, 3'd5, 8'h77, 2'd1, 0, "R2 read miss index 5");
        @(negedge clk);
        cpu_req = 1'b1; cpu_wr = 1'b1; cpu_idx = 3'd5; cpu_tag = 8'h77;
        snp_vld = 1'b1; snp_op = 2'd3; snp_idx = 3'd5; snp_tag = 8'h77;
        #1;
        check("R11 snoop blocks processor", !cpu_rdy && !bus_req,
              {30'd0, cpu_rdy, bus_req}, 32'd0);
        @(negedge clk);
        snp_vld = 1'b0;
        exp_q.push_back({2'd2, 3'd5});
        #1;
        check("R11 processor sees invalidated line", bus_req && bus_op == 2'd2,
              {29'd0, bus_req, bus_op}, 32'h6);
        @(negedge clk);
        bus_gnt = 1'b1;
        #1;
        check("R11 ready after grant", cpu_rdy, {31'd0, cpu_rdy}, 32'd1);
        @(negedge clk);
        cpu_req = 1'b0; bus_gnt = 1'b0;
        #1;
        check("R7 idle no bus request", !bus_req, {31'd0, bus_req}, 32'd0);

        check("R7 scoreboard drained", exp_q.size() == 0, exp_q.size(), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule